// File: doc/BRIEF.md
# Sub-Slot Signalling Byte Assembler

This block sits on a serial time-division multiplexed stream and carries low-rate signalling channels inside it. A frame is made of 8-bit time slots, sent one bit per clock with the most significant bit first. The lower slots carry bearer (voice) data. The block copies these to its output unchanged. The upper slots are each cut into four 2-bit sub-slots. Each sub-slot is an independent signalling channel, which gives 256 two-bit channels per frame with the default sizes.

A byte on one signalling channel needs four frames to cross the stream: one 2-bit piece per frame. On the receive side, the block collects each channel's pieces over a group of four frames. When the last piece arrives, it presents the assembled byte with a one-cycle strobe and the channel number. On the transmit side, the host loads a byte for a channel at any time. The block picks the byte up at the start of the next four-frame group and sends it one piece per frame. A channel with nothing to send carries all-ones.

The frame-sync input marks the first bit of every frame. The sync pulses also count frames within the four-frame group.

Top module: `dslot_assembler`

## Requirements
- R1: After reset and until the first frame-sync pulse, `tdm_out` is 1 and `rx_valid` is 0.
- R2: The cycle with `fsync` high carries bit 0 of slot 0. Bits follow one per cycle, 8 per slot, slots 0..127. Slots 64..127 are signalling slots. Sub-slot k of signalling slot s takes bit positions 2k and 2k+1 and is channel (s-64)*4+k.
- R3: For a bearer slot (0..63), `tdm_out` equals the `tdm_in` bit of the previous cycle.
- R4: The first `fsync` after reset starts frame phase 0. Each later `fsync` advances the phase by one, modulo 4.
- R5: In a received byte, the pair taken in frame phase p fills bits [7-2p:6-2p]. The earlier bit of a pair is its more significant bit.
- R6: `rx_valid` is high for exactly one cycle, the cycle after the second bit of a channel's sub-slot in phase 3. `rx_chan` then gives that channel and `rx_byte` gives its assembled byte. Otherwise `rx_valid` is 0.
- R7: `tx_wr` stores `tx_byte` as the pending byte of channel `tx_chan`. A second write before the pending byte is taken replaces it.
- R8: At a channel's phase-0 sub-slot, a pending byte is taken and the pending entry is cleared. The byte's pairs are sent in phases 0..3, bits [7:6] first, the higher bit of each pair first. Each bit appears on `tdm_out` one cycle after its position.
- R9: If no byte is pending at a channel's phase-0 sub-slot, the channel sends 2'b11 in all four frames of that group.
- R10: A taken byte is sent only once. The following group is idle (all ones) unless a new write arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| fsync | input | 1 | Frame sync, high during the first bit of a frame |
| tdm_in | input | 1 | Serial frame data in |
| tdm_out | output | 1 | Serial frame data out, one cycle behind its position |
| rx_valid | output | 1 | Received signalling byte strobe |
| rx_chan | output | 8 | Channel of the received byte |
| rx_byte | output | 8 | Assembled received byte |
| tx_wr | input | 1 | Load a transmit byte |
| tx_chan | input | 8 | Channel of the transmit byte |
| tx_byte | input | 8 | Transmit byte |

## Verification
Every bit of `tdm_out` is due one cycle after the input bit at the same frame position. This holds for bearer pass-through, transmitted pieces and idle ones alike. The receive strobe is due one cycle after the second bit of the phase-3 sub-slot. A transmit write takes effect at the channel's next phase-0 sub-slot, and its pieces then follow at one-frame spacing. The bench drives inputs on the falling edge and records the expected outputs for that cycle. At the next falling edge, after the rising edge has registered the result, it compares the outputs against those recorded values. Writes are placed in phase-1 bearer slots, so no write ever coincides with a channel's phase-0 sub-slot.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

    typedef enum logic {
        KIND_BEARER = 1'b0,
        KIND_SIGNAL = 1'b1
    } slot_kind_e;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    // Pick the 2-bit piece for a frame phase, first phase = top bits
    function automatic logic [1:0] pair_pick(input logic [7:0] b, input logic [1:0] ph);
        case (ph)
            2'd0:    pair_pick = b[7:6];
            2'd1:    pair_pick = b[5:4];
            2'd2:    pair_pick = b[3:2];
            default: pair_pick = b[1:0];
        endcase
    endfunction

    // Put a 2-bit piece into the byte position of a frame phase
    function automatic logic [7:0] pair_put(input logic [7:0] b, input logic [1:0] ph,
                                            input logic [1:0] pr);
        logic [7:0] r;
        r = b;
        case (ph)
            2'd0:    r[7:6] = pr;
            2'd1:    r[5:4] = pr;
            2'd2:    r[3:2] = pr;
            default: r[1:0] = pr;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dslot_timing.sv
module dslot_timing
    import dslot_pkg::*;
#(
    parameter int NUM_SLOTS    = 128,
    parameter int FIRST_D_SLOT = 64,
    localparam int NUM_CH = (NUM_SLOTS - FIRST_D_SLOT) * 4,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fsync,
    output logic            pos_sync,
    output slot_kind_e      pos_kind,
    output logic [CH_W-1:0] pos_chan,
    output logic            pos_second,
    output logic [1:0]      pos_phase
);
    logic [2:0]        bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic [1:0]        phase_q;
    logic              sync_q;

    logic [2:0]        cur_bit;
    logic [SLOT_W-1:0] cur_slot;
    logic [SLOT_W-1:0] slot_off;

    always_comb begin
        cur_bit    = fsync ? 3'd0 : bit_q;
        cur_slot   = fsync ? '0 : slot_q;
        pos_phase  = fsync ? phase_q + 2'd1 : phase_q;
        pos_sync   = fsync | sync_q;
        pos_kind   = (cur_slot >= SLOT_W'(FIRST_D_SLOT)) ? KIND_SIGNAL : KIND_BEARER;
        slot_off   = cur_slot - SLOT_W'(FIRST_D_SLOT);
        pos_chan   = {slot_off[CH_W-3:0], cur_bit[2:1]};
        pos_second = cur_bit[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q   <= '0;
            slot_q  <= '0;
            phase_q <= 2'd3;
            sync_q  <= 1'b0;
        end else begin
            bit_q   <= cur_bit + 3'd1;
            phase_q <= pos_phase;
            sync_q  <= pos_sync;
            if (cur_bit == 3'd7)
                slot_q <= (cur_slot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : cur_slot + 1'b1;
            else
                slot_q <= cur_slot;
        end
    end
endmodule

// File: rtl/dslot_rx.sv
module dslot_rx
    import dslot_pkg::*;
#(
    parameter int NUM_CH = 256,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tdm_in,
    input  logic            pos_sync,
    input  slot_kind_e      pos_kind,
    input  logic [CH_W-1:0] pos_chan,
    input  logic            pos_second,
    input  logic [1:0]      pos_phase,
    output logic            rx_valid,
    output logic [CH_W-1:0] rx_chan,
    output logic [7:0]      rx_byte
);
    logic [7:0] acc_q [NUM_CH];
    logic       first_q;
    logic [1:0] pair;
    logic       take;

    assign pair = {first_q, tdm_in};
    assign take = pos_sync && (pos_kind == KIND_SIGNAL) && pos_second;

    always_ff @(posedge clk) begin
        if (pos_sync && (pos_kind == KIND_SIGNAL) && !pos_second)
            first_q <= tdm_in;
        if (take)
            acc_q[pos_chan] <= pair_put(acc_q[pos_chan], pos_phase, pair);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_chan  <= '0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= take && (pos_phase == 2'd3);
            if (take && (pos_phase == 2'd3)) begin
                rx_chan <= pos_chan;
                rx_byte <= {acc_q[pos_chan][7:2], pair};
            end
        end
    end
endmodule

// File: rtl/dslot_tx.sv
module dslot_tx
    import dslot_pkg::*;
#(
    parameter int NUM_CH = 256,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tdm_in,
    input  logic            pos_sync,
    input  slot_kind_e      pos_kind,
    input  logic [CH_W-1:0] pos_chan,
    input  logic            pos_second,
    input  logic [1:0]      pos_phase,
    input  logic            tx_wr,
    input  logic [CH_W-1:0] tx_chan,
    input  logic [7:0]      tx_byte,
    output logic            tdm_out
);
    logic [7:0]        pend_q [NUM_CH];
    logic [NUM_CH-1:0] pend_v_q;
    logic [7:0]        cur_q  [NUM_CH];

    logic       start;
    logic [7:0] load, sel;
    logic [1:0] piece;
    logic       out_bit;

    always_comb begin
        start = pos_sync && (pos_kind == KIND_SIGNAL) && (pos_phase == 2'd0) && !pos_second;
        load  = pend_v_q[pos_chan] ? pend_q[pos_chan] : IDLE_BYTE;
        sel   = start ? load : cur_q[pos_chan];
        piece = pair_pick(sel, pos_phase);
        if (!pos_sync)
            out_bit = 1'b1;
        else if (pos_kind == KIND_SIGNAL)
            out_bit = pos_second ? piece[0] : piece[1];
        else
            out_bit = tdm_in;
    end

    always_ff @(posedge clk) begin
        if (tx_wr)
            pend_q[tx_chan] <= tx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v_q <= '0;
            tdm_out  <= 1'b1;
            for (int i = 0; i < NUM_CH; i++)
                cur_q[i] <= IDLE_BYTE;
        end else begin
            tdm_out <= out_bit;
            if (start) begin
                cur_q[pos_chan]    <= load;
                pend_v_q[pos_chan] <= 1'b0;
            end
            if (tx_wr)
                pend_v_q[tx_chan] <= 1'b1;
        end
    end
endmodule

// File: rtl/dslot_assembler.sv
module dslot_assembler
    import dslot_pkg::*;
#(
    parameter int NUM_SLOTS    = 128,
    parameter int FIRST_D_SLOT = 64,
    localparam int NUM_CH = (NUM_SLOTS - FIRST_D_SLOT) * 4,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fsync,
    input  logic            tdm_in,
    output logic            tdm_out,
    output logic            rx_valid,
    output logic [CH_W-1:0] rx_chan,
    output logic [7:0]      rx_byte,
    input  logic            tx_wr,
    input  logic [CH_W-1:0] tx_chan,
    input  logic [7:0]      tx_byte
);
    logic            pos_sync;
    slot_kind_e      pos_kind;
    logic [CH_W-1:0] pos_chan;
    logic            pos_second;
    logic [1:0]      pos_phase;
    logic            pos_is_d;

    assign pos_is_d = (pos_kind == KIND_SIGNAL);

    dslot_timing #(.NUM_SLOTS(NUM_SLOTS), .FIRST_D_SLOT(FIRST_D_SLOT)) u_timing (
        .clk, .rst, .fsync,
        .pos_sync, .pos_kind, .pos_chan, .pos_second, .pos_phase
    );

    dslot_rx #(.NUM_CH(NUM_CH)) u_rx (
        .clk, .rst, .tdm_in,
        .pos_sync, .pos_kind, .pos_chan, .pos_second, .pos_phase,
        .rx_valid, .rx_chan, .rx_byte
    );

    dslot_tx #(.NUM_CH(NUM_CH)) u_tx (
        .clk, .rst, .tdm_in,
        .pos_sync, .pos_kind, .pos_chan, .pos_second, .pos_phase,
        .tx_wr, .tx_chan, .tx_byte, .tdm_out
    );
endmodule

// File: rtl/dslot_assembler_chk.sv
module dslot_assembler_chk (
    input logic clk,
    input logic rst,
    input logic fsync,
    input logic tdm_in,
    input logic tdm_out,
    input logic rx_valid,
    input logic tx_wr,
    input logic pos_sync,
    input logic pos_is_d
);
    logic       seen_q;
    logic       any_wr_q;
    logic [1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q   <= 1'b0;
            any_wr_q <= 1'b0;
            ph_q     <= 2'd3;
        end else begin
            if (fsync) begin
                seen_q <= 1'b1;
                ph_q   <= ph_q + 2'd1;
            end
            if (tx_wr)
                any_wr_q <= 1'b1;
        end
    end

    // R1: quiet until the first frame sync
    p_idle_unsynced_r1: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> (tdm_out && !rx_valid));

    // R3: bearer bits pass through one cycle later
    p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
        $past(pos_sync && !pos_is_d) |-> (tdm_out == $past(tdm_in)));

    // R6: strobe only for the last frame of a group
    p_strobe_phase_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (ph_q == 2'd3));

    // R6: strobe lasts one cycle
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9: without any write, signalling bits stay at one
    p_idle_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        (!any_wr_q && $past(pos_sync && pos_is_d)) |-> tdm_out);
endmodule

bind dslot_assembler dslot_assembler_chk u_chk (
    .clk(clk), .rst(rst), .fsync(fsync), .tdm_in(tdm_in), .tdm_out(tdm_out),
    .rx_valid(rx_valid), .tx_wr(tx_wr), .pos_sync(pos_sync), .pos_is_d(pos_is_d)
);

// File: tb/dslot_assembler_test.sv
module dslot_assembler_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       fsync;
    logic       tdm_in;
    logic       tdm_out;
    logic       rx_valid;
    logic [7:0] rx_chan;
    logic [7:0] rx_byte;
    logic       tx_wr;
    logic [7:0] tx_chan;
    logic [7:0] tx_byte;

    always #2.5 clk = ~clk;

    dslot_assembler uut (
        .clk, .rst, .fsync, .tdm_in, .tdm_out,
        .rx_valid, .rx_chan, .rx_byte,
        .tx_wr, .tx_chan, .tx_byte
    );

    int tests = 0;
    int fails = 0;

    // bench model state
    logic [7:0] rxg    [256];
    logic [7:0] pend_m [256];
    logic       pv_m   [256];
    logic [7:0] cur_m  [256];
    logic       ld_m   [256];

    // expectations for the cycle just driven
    logic       p_on;
    logic       p_out;
    logic       p_rv;
    logic [7:0] p_ch;
    logic [7:0] p_byte;
    string      p_tag;
    string      p_rtag;

    task automatic check_prev();
        if (!p_on) return;
        tests++;
        if (tdm_out !== p_out) begin
            fails++;
            $display("FAIL %s tdm_out actual=%0b expected=%0b", p_tag, tdm_out, p_out);
        end
        tests++;
        if (rx_valid !== p_rv) begin
            fails++;
            $display("FAIL R6 rx_valid actual=%0b expected=%0b", rx_valid, p_rv);
        end else if (p_rv) begin
            tests++;
            if (rx_chan !== p_ch || rx_byte !== p_byte) begin
                fails++;
                $display("FAIL %s rx chan/byte actual=%0d/%h expected=%0d/%h",
                         p_rtag, rx_chan, rx_byte, p_ch, p_byte);
            end
        end
    endtask

    function automatic logic model_bit(input int ch, input int f, input int bb);
        if (f == 0 && bb == 0) begin
            cur_m[ch] = pv_m[ch] ? pend_m[ch] : 8'hFF;
            ld_m[ch]  = pv_m[ch];
            pv_m[ch]  = 1'b0;
        end
        return cur_m[ch][7 - 2*f - bb];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            pv_m[i] = 1'b0; cur_m[i] = 8'hFF; ld_m[i] = 1'b0; pend_m[i] = 8'h00;
        end
    endtask

    // R1: idle cycles with no frame sync
    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_prev();
            fsync = 1'b0; tdm_in = 1'($urandom % 2); tx_wr = 1'b0;
            p_on = 1'b1; p_out = 1'b1; p_rv = 1'b0; p_tag = "R1";
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_prev();
        rst = 1'b1; fsync = 1'b0; tx_wr = 1'b0;
        p_on = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: reset state of the outputs
        tests++;
        if (tdm_out !== 1'b1 || rx_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%0b/%0b expected=1/0", tdm_out, rx_valid);
        end
    endtask

    // modes: 0 no writes, 1 random writes, 2 directed writes, 3 no writes after 2, 4 after reset
    task automatic run_group(input int mode);
        for (int c = 0; c < 256; c++)
            rxg[c] = (mode == 2) ? 8'(c ^ 8'h5A) : 8'($urandom);
        rxg[0]   = (mode == 2) ? 8'h00 : rxg[0];
        rxg[255] = (mode == 2) ? 8'hFF : rxg[255];
        for (int f = 0; f < 4; f++)
            for (int s = 0; s < 128; s++)
                for (int b = 0; b < 8; b++) begin
                    int  ch, bb;
                    logic din, eo, wr;
                    logic [7:0] wch, wb;
                    @(negedge clk);
                    check_prev();
                    bb = b % 2;
                    ch = (s - 64) * 4 + b / 2;
                    wr = 1'b0; wch = 8'h00; wb = 8'h00;
                    if (f == 1 && s < 64 && b == 0) begin
                        if (mode == 1 || mode == 4) begin
                            if ($urandom % 4 == 0) begin
                                wr = 1'b1; wch = 8'($urandom); wb = 8'($urandom);
                            end
                        end else if (mode == 2) begin
                            // R7: channel 0 written twice, second value wins
                            if (s == 0) begin wr = 1'b1; wch = 8'd0;   wb = 8'hA5; end
                            if (s == 1) begin wr = 1'b1; wch = 8'd0;   wb = 8'h3C; end
                            if (s == 2) begin wr = 1'b1; wch = 8'd255; wb = 8'h81; end
                            if (s == 3) begin wr = 1'b1; wch = 8'd17;  wb = 8'h00; end
                        end
                    end
                    if (s >= 64) begin
                        din = rxg[ch][7 - 2*f - bb];
                        eo  = model_bit(ch, f, bb);
                        if (ld_m[ch])       p_tag = (ch == 0 && mode == 2) ? "R7" : "R8";
                        else if (mode == 3) p_tag = "R10";
                        else                p_tag = "R9";
                        p_rv = (f == 3 && bb == 1);
                        p_ch = 8'(ch); p_byte = rxg[ch];
                        p_rtag = (mode == 4) ? "R4" : "R5";
                    end else begin
                        din = 1'($urandom % 2);
                        eo  = din;
                        p_tag = "R3";
                        p_rv = 1'b0;
                    end
                    fsync = (s == 0 && b == 0);
                    tdm_in = din;
                    tx_wr = wr; tx_chan = wch; tx_byte = wb;
                    p_on = 1'b1; p_out = eo;
                    if (wr) begin
                        pend_m[wch] = wb; pv_m[wch] = 1'b1;
                    end
                end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; fsync = 1'b0; tdm_in = 1'b0;
        tx_wr = 1'b0; tx_chan = '0; tx_byte = '0;
        p_on = 1'b0; p_out = 1'b1; p_rv = 1'b0; p_ch = '0; p_byte = '0;
        p_tag = "R1"; p_rtag = "R5";
        model_reset();
        do_reset();
        idle_cycles(20);           // R1
        run_group(0);              // R9 idle, R2 decode, R5 packing
        run_group(1);              // R8 random loads
        run_group(2);              // R7 overwrite, R8 edge channels
        run_group(1);              // R8 emission of directed bytes
        run_group(3);              // R10 sent once
        do_reset();
        idle_cycles(10);           // R1 after second reset
        run_group(4);              // R4 phase restarts at 0
        run_group(1);
        @(negedge clk);
        check_prev();
        finish_run();
    end
endmodule